// File: doc/BRIEF.md
# Three-Level Page Table Walk Engine

This block turns a virtual address into a physical address by reading a tree of translation tables held in ordinary memory. A request brings the current context number, the base pointer of the context table, a 32-bit virtual address, the kind of access (read, write or execute) and whether the requester runs in user mode. The engine reads one word per lookup over a single-word memory port: the context entry first, then the region, segment and page tables in turn.

Every entry carries a two-bit type. The walk follows pointer entries downward and expects a leaf at the page level. On the leaf it applies a three-bit combined user/supervisor rights code. A successful walk returns a 36-bit physical address and a cacheable flag. If the used or dirty flag in the leaf has to change, the updated leaf is written back to the same location first. A failed walk returns a fault class and the level at which it stopped. The engine takes a new request only while idle and keeps at most one memory access outstanding.

Top module: `pgwalk_top`

## Requirements
- R1: After reset the engine is idle: `req_ready` is 1, and `mem_req` and `resp_valid` are both 0.
- R2: The first read goes to the context entry at (ctp with bits 1:0 cleared, shifted left by 4) + 4*ctx. Each later read goes to (previous entry with bits 1:0 cleared, shifted left by 4) + 4*index. The index is va[31:24] for the region table, va[23:18] for the segment table and va[17:12] for the page table. All addresses are 36 bits.
- R3: Entry type is bits 1:0: 0 invalid, 1 pointer, 2 leaf, 3 reserved. The lookups at levels 0 (context), 1 (region) and 2 (segment) must return type 1, and level 3 (page) must return type 2. Any other type ends the walk with no further memory access, fault code 1 and `resp_level` equal to the failing level.
- R4: On success `resp_fault` is 0, `resp_level` is 3, `resp_pa` is {leaf[31:8], va[11:0]} and `resp_cacheable` is leaf bit 7.
- R5: Leaf bits 4:2 hold the rights code. As user/supervisor rights, codes 0..7 grant R/R, RW/RW, RX/RX, RWX/RWX, X/X, R/RW, none/RX and none/RWX. Kind encoding: 0 read, 1 write, 2 execute. Kind 3 is never granted. A user access with code 6 or 7 is always refused.
- R6: A refused access ends the walk with fault code 2 and `resp_level` 3, and no writeback is made.
- R7: On success the leaf gets bit 5 (used) set, and also bit 6 (dirty) when the kind is write. The updated leaf is written to the leaf's own address only when it differs from the value read. Otherwise no write is issued.
- R8: `mem_req` stays high with a stable address and direction until `mem_ack`. A request is taken only while `req_ready` is 1. `req_valid` while busy is ignored.
- R9: `resp_valid` is a one-cycle pulse, exactly one per accepted request. Fault codes are 0 none, 1 bad entry type and 2 protection. On a fault `resp_pa` is 0 and `resp_cacheable` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_ctx | input | 4 | Context number |
| req_ctp | input | 32 | Context table pointer |
| req_va | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_user | input | 1 | 1 for a user-mode access |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write access |
| mem_addr | output | 36 | Word address in bytes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| resp_valid | output | 1 | Result pulse |
| resp_fault | output | 2 | Fault class |
| resp_level | output | 2 | Level where the walk stopped |
| resp_pa | output | 36 | Physical address |
| resp_cacheable | output | 1 | Leaf cacheable flag |

## Verification
The walk is tried with clean pointer chains ending in leaves whose used/dirty flags are clear, half set and fully set. These tell a required writeback apart from a skipped one, and a read's update apart from a write's. Chains are broken at each of the four levels with invalid, reserved, misplaced-leaf and misplaced-pointer types, which shows that the walk stops at the right depth without extra reads. A sweep of all eight rights codes against every kind and both modes separates the protection table from the type checks. A context pointer with high bits set exercises the full 36-bit address path. Requests offered while a walk is in progress, and memory latencies that vary per access, probe the handshake.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    localparam int VA_W   = 32;
    localparam int ENT_W  = 32;
    localparam int PA_W   = 36;
    localparam int CTX_W  = 4;
    localparam int LVL_W  = 2;
    localparam int OFF_W  = 12;
    localparam int PPN_W  = ENT_W - 8;
    localparam int BASE_SH = PA_W - ENT_W;
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(3);

    localparam logic [ENT_W-1:0] USED_BIT  = ENT_W'(32'h20);
    localparam logic [ENT_W-1:0] DIRTY_BIT = ENT_W'(32'h40);

    typedef enum logic [1:0] {ET_INV, ET_PTR, ET_LEAF, ET_RSVD} ent_type_e;
    typedef enum logic [1:0] {AK_READ, AK_WRITE, AK_EXEC, AK_RSVD} acc_kind_e;
    typedef enum logic [1:0] {FS_NONE, FS_TYPE, FS_PROT, FS_UNUSED} fault_e;
    typedef enum logic [1:0] {S_IDLE, S_READ, S_WBACK, S_RESP} walk_st_e;

    typedef struct packed {
        logic [CTX_W-1:0] ctx;
        logic [ENT_W-1:0] ctp;
        logic [VA_W-1:0]  va;
        acc_kind_e        kind;
        logic             user;
    } walk_req_t;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic             cach;
        logic             dirty;
        logic             used;
        logic [2:0]       rights;
        ent_type_e        et;
    } leaf_t;

    function automatic logic [PA_W-1:0] tbl_base(input logic [ENT_W-1:0] e);
        logic [PA_W-1:0] b;
        b = {{BASE_SH{1'b0}}, e[ENT_W-1:2], 2'b00};
        return b << BASE_SH;
    endfunction

endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr
    import pgwalk_pkg::*;
(
    input  logic [LVL_W-1:0] lvl,
    input  walk_req_t        rq,
    input  logic [ENT_W-1:0] ptr,
    output logic [PA_W-1:0]  addr
);
    logic [PA_W-1:0] base;
    logic [7:0]      idx;

    always_comb begin
        base = tbl_base(ptr);
        idx  = '0;
        case (lvl)
            2'd0: begin
                base = tbl_base(rq.ctp);
                idx  = 8'(rq.ctx);
            end
            2'd1: idx = rq.va[31:24];
            2'd2: idx = 8'(rq.va[23:18]);
            default: idx = 8'(rq.va[17:12]);
        endcase
        addr = base + PA_W'({idx, 2'b00});
    end
endmodule

// File: rtl/pgwalk_perm.sv
module pgwalk_perm
    import pgwalk_pkg::*;
(
    input  logic [2:0] rights,
    input  acc_kind_e  kind,
    input  logic       user,
    output logic       ok
);
    // one bit per rights code, bit n = code n
    localparam logic [7:0] USR_R = 8'b0010_1111;
    localparam logic [7:0] USR_W = 8'b0000_1010;
    localparam logic [7:0] USR_X = 8'b0001_1100;
    localparam logic [7:0] SUP_R = 8'b1110_1111;
    localparam logic [7:0] SUP_W = 8'b1010_1010;
    localparam logic [7:0] SUP_X = 8'b1101_1100;

    logic [7:0] m_r, m_w, m_x, sel;

    always_comb begin
        m_r = user ? USR_R : SUP_R;
        m_w = user ? USR_W : SUP_W;
        m_x = user ? USR_X : SUP_X;
        case (kind)
            AK_READ:  sel = m_r;
            AK_WRITE: sel = m_w;
            AK_EXEC:  sel = m_x;
            default:  sel = 8'h00;
        endcase
        ok = sel[rights];
    end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [3:0]  req_ctx,
    input  logic [31:0] req_ctp,
    input  logic [31:0] req_va,
    input  logic [1:0]  req_kind,
    input  logic        req_user,
    output logic        mem_req,
    output logic        mem_we,
    output logic [35:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack,
    output logic        resp_valid,
    output logic [1:0]  resp_fault,
    output logic [1:0]  resp_level,
    output logic [35:0] resp_pa,
    output logic        resp_cacheable
);
    walk_st_e         st;
    logic [LVL_W-1:0] lvl;
    walk_req_t        rq;
    logic [ENT_W-1:0] ptr;
    logic [ENT_W-1:0] upd;
    fault_e           flt_q;
    logic [PA_W-1:0]  pa_q;
    logic             cach_q;

    leaf_t            rd_leaf;
    ent_type_e        rd_type;
    logic             perm_ok;
    logic [ENT_W-1:0] upd_next;

    assign rd_leaf = leaf_t'(mem_rdata);
    assign rd_type = rd_leaf.et;

    pgwalk_addr u_addr (
        .lvl  (lvl),
        .rq   (rq),
        .ptr  (ptr),
        .addr (mem_addr)
    );

    pgwalk_perm u_perm (
        .rights (rd_leaf.rights),
        .kind   (rq.kind),
        .user   (rq.user),
        .ok     (perm_ok)
    );

    always_comb begin
        upd_next = mem_rdata | USED_BIT;
        if (rq.kind == AK_WRITE) upd_next = upd_next | DIRTY_BIT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            lvl    <= '0;
            rq     <= '0;
            ptr    <= '0;
            upd    <= '0;
            flt_q  <= FS_NONE;
            pa_q   <= '0;
            cach_q <= 1'b0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (req_valid) begin
                        rq.ctx  <= req_ctx;
                        rq.ctp  <= req_ctp;
                        rq.va   <= req_va;
                        rq.kind <= acc_kind_e'(req_kind);
                        rq.user <= req_user;
                        lvl     <= '0;
                        st      <= S_READ;
                    end
                end
                S_READ: begin
                    if (mem_ack) begin
                        if (lvl != LAST_LVL) begin
                            if (rd_type == ET_PTR) begin
                                ptr <= mem_rdata;
                                lvl <= lvl + LVL_W'(1);
                            end else begin
                                flt_q  <= FS_TYPE;
                                pa_q   <= '0;
                                cach_q <= 1'b0;
                                st     <= S_RESP;
                            end
                        end else if (rd_type != ET_LEAF) begin
                            flt_q  <= FS_TYPE;
                            pa_q   <= '0;
                            cach_q <= 1'b0;
                            st     <= S_RESP;
                        end else if (!perm_ok) begin
                            flt_q  <= FS_PROT;
                            pa_q   <= '0;
                            cach_q <= 1'b0;
                            st     <= S_RESP;
                        end else begin
                            flt_q  <= FS_NONE;
                            pa_q   <= {rd_leaf.ppn, rq.va[OFF_W-1:0]};
                            cach_q <= rd_leaf.cach;
                            upd    <= upd_next;
                            st     <= (upd_next != mem_rdata) ? S_WBACK : S_RESP;
                        end
                    end
                end
                S_WBACK: begin
                    if (mem_ack) st <= S_RESP;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign req_ready      = (st == S_IDLE);
    assign mem_req        = (st == S_READ) || (st == S_WBACK);
    assign mem_we         = (st == S_WBACK);
    assign mem_wdata      = upd;
    assign resp_valid     = (st == S_RESP);
    assign resp_fault     = flt_q;
    assign resp_level     = lvl;
    assign resp_pa        = pa_q;
    assign resp_cacheable = cach_q;

endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_ready,
    input logic        mem_req,
    input logic        mem_we,
    input logic [35:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        mem_ack,
    input logic        resp_valid,
    input logic [1:0]  resp_fault,
    input logic [1:0]  resp_level,
    input logic [35:0] resp_pa,
    input logic        resp_cacheable
);
    p_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!mem_req && !resp_valid));

    p_resp_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> (!resp_valid && req_ready));

    p_fault_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fault != 2'd0) |-> (resp_pa == 36'd0 && !resp_cacheable));

    p_fault_code_r9: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> (resp_fault != 2'd3));

    p_prot_level_r6: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fault != 2'd1) |-> (resp_level == 2'd3));

    p_wb_used_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_wdata[5] && mem_wdata[1:0] == 2'd2));

endmodule

bind pgwalk_top pgwalk_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_ready      (req_ready),
    .mem_req        (mem_req),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata),
    .mem_ack        (mem_ack),
    .resp_valid     (resp_valid),
    .resp_fault     (resp_fault),
    .resp_level     (resp_level),
    .resp_pa        (resp_pa),
    .resp_cacheable (resp_cacheable)
);

// File: tb/sim_pgwalk_top.sv
module sim_pgwalk_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_ctx = '0;
    logic [31:0] req_ctp = '0;
    logic [31:0] req_va = '0;
    logic [1:0]  req_kind = '0;
    logic        req_user = 1'b0;
    logic        mem_req, mem_we;
    logic [35:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        resp_valid;
    logic [1:0]  resp_fault, resp_level;
    logic [35:0] resp_pa;
    logic        resp_cacheable;

    always #4 clk = ~clk;

    pgwalk_top u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_ctx(req_ctx), .req_ctp(req_ctp), .req_va(req_va),
        .req_kind(req_kind), .req_user(req_user),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_level(resp_level),
        .resp_pa(resp_pa), .resp_cacheable(resp_cacheable)
    );

    typedef struct {
        logic [35:0] a;
        logic        we;
        logic [31:0] d;
    } acc_t;

    logic [31:0] mem [logic [35:0]];
    acc_t        exp_q[$];
    int          checks = 0;
    int          fails = 0;
    int          lat = 0;
    bit          exp_pend = 0;
    logic [1:0]  e_fault, e_lvl;
    logic [35:0] e_pa;
    logic        e_c;

    localparam logic [31:0] CTP0 = 32'h0001_0000;

    function automatic logic [31:0] rdw(logic [35:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic logic [35:0] base_of(logic [31:0] e);
        logic [35:0] b;
        b = {4'h0, e & 32'hFFFF_FFFC};
        return b << 4;
    endfunction

    function automatic bit allowed(logic [2:0] code, logic [1:0] kind, bit user);
        string ur[8] = '{"R", "RW", "RX", "RWX", "X", "R", "", ""};
        string sr[8] = '{"R", "RW", "RX", "RWX", "X", "RW", "RX", "RWX"};
        string s;
        byte   ch;
        if (kind == 2'd0) ch = "R";
        else if (kind == 2'd1) ch = "W";
        else if (kind == 2'd2) ch = "X";
        else return 0;
        s = user ? ur[code] : sr[code];
        for (int i = 0; i < s.len(); i++) if (s[i] == ch) return 1;
        return 0;
    endfunction

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // behavioural walk: fills the expected access list and result
    task automatic ref_walk(logic [3:0] ctx, logic [31:0] ctp, logic [31:0] va,
                            logic [1:0] kind, bit user);
        logic [35:0] a;
        logic [31:0] e, ne;
        int idx;
        acc_t x;
        e_fault = 0; e_pa = 0; e_c = 0;
        a = base_of(ctp) + 36'(ctx) * 4;
        for (int l = 0; l < 4; l++) begin
            e = rdw(a);
            x.a = a; x.we = 0; x.d = 0;
            exp_q.push_back(x);
            e_lvl = 2'(l);
            if ((l < 3 && e[1:0] != 2'd1) || (l == 3 && e[1:0] != 2'd2)) begin
                e_fault = 1;
                return;
            end
            if (l < 3) begin
                if (l == 0) idx = int'(va[31:24]);
                else if (l == 1) idx = int'(va[23:18]);
                else idx = int'(va[17:12]);
                a = base_of(e) + 36'(idx) * 4;
            end
        end
        if (!allowed(e[4:2], kind, user)) begin
            e_fault = 2;
            return;
        end
        ne = e | 32'h20;
        if (kind == 2'd1) ne = ne | 32'h40;
        if (ne != e) begin
            x.a = a; x.we = 1; x.d = ne;
            exp_q.push_back(x);
        end
        e_pa = {e[31:8], va[11:0]};
        e_c  = e[7];
    endtask

    // memory model and per-clock comparison
    always @(negedge clk) begin
        if (resp_valid) begin
            if (!exp_pend) check(0, "R9", "unexpected response", 1, 0);
            else begin
                check(resp_fault == e_fault, "R3", "fault class", resp_fault, e_fault);
                check(resp_level == e_lvl, "R3", "stop level", resp_level, e_lvl);
                check(resp_pa == e_pa, "R4", "physical address", resp_pa, e_pa);
                check(resp_cacheable == e_c, "R4", "cacheable", resp_cacheable, e_c);
                check(exp_q.size() == 0, "R7", "accesses left", exp_q.size(), 0);
                exp_pend = 0;
            end
        end
        if (rst) mem_ack = 0;
        else if (mem_ack) mem_ack = 0;
        else if (mem_req) begin
            if (lat > 0) lat--;
            else begin
                if (exp_q.size() == 0) check(0, "R3", "extra access", mem_addr, 0);
                else begin
                    acc_t h;
                    h = exp_q.pop_front();
                    check(mem_addr == h.a, "R2", "access address", mem_addr, h.a);
                    check(mem_we == h.we, "R7", "access direction", mem_we, h.we);
                    if (h.we) check(mem_wdata == h.d, "R7", "writeback data", mem_wdata, h.d);
                end
                if (mem_we) mem[mem_addr] = mem_wdata;
                else mem_rdata = rdw(mem_addr);
                mem_ack = 1;
                lat = $urandom_range(0, 2);
            end
        end
    end

    function automatic logic [31:0] mk_leaf(logic [23:0] ppn, bit c, bit m, bit r,
                                            logic [2:0] code, logic [1:0] t);
        return {ppn, c, m, r, code, t};
    endfunction

    task automatic build(logic [31:0] ctp, logic [3:0] ctx, logic [31:0] va,
                         logic [1:0] t0, logic [1:0] t1, logic [1:0] t2, logic [31:0] leaf);
        mem[base_of(ctp) + 36'(ctx) * 4]             = 32'h0002_0000 | 32'(t0);
        mem[36'h20_0000 + 36'(va[31:24]) * 4]       = 32'h0003_0000 | 32'(t1);
        mem[36'h30_0000 + 36'(va[23:18]) * 4]       = 32'h0004_0000 | 32'(t2);
        mem[36'h40_0000 + 36'(va[17:12]) * 4]       = leaf;
    endtask

    task automatic issue(logic [3:0] ctx, logic [31:0] ctp, logic [31:0] va,
                         logic [1:0] kind, bit user, bit poke);
        int n;
        while (!req_ready) @(negedge clk);
        ref_walk(ctx, ctp, va, kind, user);
        exp_pend = 1;
        req_ctx = ctx; req_ctp = ctp; req_va = va; req_kind = kind; req_user = user;
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        if (poke) begin
            // R8: offers while busy must be ignored
            for (int i = 0; i < 3; i++) begin
                check(req_ready == 0, "R8", "busy ready", req_ready, 0);
                req_va = va ^ 32'h0100_0000;
                req_valid = 1;
                @(negedge clk);
            end
            req_valid = 0;
        end
        n = 0;
        while (exp_pend && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (exp_pend) begin
            check(0, "R9", "response timeout", 0, 1);
            exp_pend = 0;
            exp_q.delete();
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog expired: actual 0 expected 1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] va;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1, "R1", "ready after reset", req_ready, 1);
        check(mem_req == 0, "R1", "mem_req after reset", mem_req, 0);
        check(resp_valid == 0, "R1", "resp_valid after reset", resp_valid, 0);

        // R4 R7: user read, used bit set by writeback
        va = 32'h1234_5678;
        build(CTP0, 4'd3, va, 1, 1, 1, mk_leaf(24'hABCDE1, 1, 0, 0, 3'd0, 2'd2));
        issue(4'd3, CTP0, va, 2'd0, 1, 0);
        // R7: same walk again, nothing changes, no write
        issue(4'd3, CTP0, va, 2'd0, 1, 0);
        // R7: supervisor write on code 5 sets dirty
        va = 32'h89AB_C123;
        build(CTP0, 4'd7, va, 1, 1, 1, mk_leaf(24'h00F00D, 0, 0, 1, 3'd5, 2'd2));
        issue(4'd7, CTP0, va, 2'd1, 0, 0);
        // R6: user write on code 5 refused
        issue(4'd7, CTP0, va, 2'd1, 1, 0);

        // R3: broken chains at every level
        va = 32'h4455_6000;
        build(CTP0, 4'd1, va, 3, 1, 1, mk_leaf(24'h1, 1, 0, 0, 3'd3, 2'd2));
        issue(4'd1, CTP0, va, 2'd0, 0, 0);
        build(CTP0, 4'd1, va, 1, 0, 1, mk_leaf(24'h1, 1, 0, 0, 3'd3, 2'd2));
        issue(4'd1, CTP0, va, 2'd0, 0, 0);
        build(CTP0, 4'd1, va, 1, 1, 2, mk_leaf(24'h1, 1, 0, 0, 3'd3, 2'd2));
        issue(4'd1, CTP0, va, 2'd0, 0, 0);
        build(CTP0, 4'd1, va, 1, 1, 1, mk_leaf(24'h1, 1, 0, 0, 3'd3, 2'd1));
        issue(4'd1, CTP0, va, 2'd0, 0, 0);

        // R2: context table high in the 36-bit space
        va = 32'hFEDC_BA98;
        build(32'hF000_0040, 4'd15, va, 1, 1, 1, mk_leaf(24'hFFFFFF, 1, 1, 1, 3'd7, 2'd2));
        issue(4'd15, 32'hF000_0040, va, 2'd2, 0, 0);

        // R5 R6: all rights codes, kinds, modes
        for (int code = 0; code < 8; code++)
            for (int k = 0; k < 3; k++)
                for (int u = 0; u < 2; u++) begin
                    va = {8'(code + 8'h10), 6'(k), 6'(u + 2 * code), 12'h5A5};
                    build(CTP0, 4'd2, va, 1, 1, 1,
                          mk_leaf(24'(code * 16 + k * 4 + u), code[0], 0, 0, 3'(code), 2'd2));
                    issue(4'd2, CTP0, va, 2'(k), u[0], 0);
                end
        // R5: reserved kind is never granted
        issue(4'd2, CTP0, va, 2'd3, 0, 0);

        // R8: requests offered while busy are dropped
        va = 32'h0F0F_0F0F;
        build(CTP0, 4'd9, va, 1, 1, 1, mk_leaf(24'h123456, 0, 0, 0, 3'd1, 2'd2));
        issue(4'd9, CTP0, va, 2'd1, 1, 1);
        repeat (10) @(negedge clk);
        check(req_ready == 1, "R8", "idle after poke run", req_ready, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule